// File: doc/BRIEF.md
# SCSI Controller Command Sequencer

This block sits behind the command register of a SCSI initiator controller. Each byte written there is split into a DMA flag (bit 7) and a seven-bit opcode (bits 6:0). The sequencer then carries out the matching controller action. It updates the status, interrupt-cause, sequence-step and FIFO-flag registers, and it raises the interrupt line when the action calls for it.

Toward the FIFO it pulses a clear, and it pushes the two-byte completion response. Toward the transfer counter it pulses a reload whenever a command carries the DMA flag.

Toward the target it drives a simplified device port. A present-device vector selects between the absent-target path and the issue path. A one-cycle issue strobe carries the target number and the LUN. The device answers with an acknowledge that carries a signed expected data length, where positive means data toward the initiator. It later signals completion with a status byte.

Select with attention either issues the command at once or holds it, so that a later transfer-information command issues it. Bus-level phase timing, arbitration and synchronous negotiation are not modelled.

Top module: `scsi_cmd_seq`

## Requirements
- R1: A command write stores the whole byte in the command register output. When bit 7 (DMA flag) is set, `xfer_start` pulses for one cycle after the write. A chip reset instead clears the command register to 0x00.
- R2: Opcode 0x02 (chip reset) is accepted in every state. It clears status, interrupt cause, sequence step, flags, the held command and the active-device flag. It lowers the interrupt, aborts a response in progress and pulses `fifo_clear`.
- R3: Opcode 0x01 (flush) sets interrupt cause 0x08, sequence step 0 and flags 0. It pulses `fifo_clear` and leaves the interrupt line as it was.
- R4: Opcode 0x03 (bus reset) sets interrupt cause 0x80. It raises the interrupt only when `cfg1` bit 6 is 0.
- R5: For opcodes 0x42 and 0x43 the target is `bus_id[2:0]`. If `dev_present` has that bit clear, status becomes 0x80 (interrupt bit 7 set, all else 0), interrupt cause becomes 0x20 and sequence step becomes 0. Any select also pulses `fifo_clear`.
- R6: Opcode 0x42 with the target present drives `dev_issue` high for exactly one cycle, starting the cycle after the write. With it come `dev_target` and `dev_lun`. The LUN is 0 without the DMA flag and `dma_cmd_byte[2:0]` with it.
- R7: On `dev_ack` after an issue, interrupt cause becomes 0x18, sequence step becomes 4 and the interrupt is raised. A nonzero length also sets status bits 6:0 to 0x10 plus the phase: 1 for a positive length, 0 for a negative one. A zero length leaves those bits unchanged.
- R8: Opcode 0x43 with the target present issues nothing. It holds the command, sets status bits 6:0 to 0x12, interrupt cause to 0x18 and sequence step to 4, and raises the interrupt. The next opcode 0x10 issues the held target and LUN as in R6.
- R9: Opcode 0x10 with no held command issues nothing. With the DMA flag it clears status bit 4 (terminal count).
- R10: Opcode 0x11 pushes the last device status byte and then 0x00 into the FIFO on two consecutive cycles, and it raises the interrupt. With the DMA flag, status bits 6:0 become 0x13, interrupt cause 0x18 and sequence step 4. Without it, flags become 2.
- R11: Opcode 0x12 acts as R10, then sets interrupt cause 0x20 and sequence step 0.
- R12: `dev_done` while a device is active stores `dev_status` as the last status. It sets status bits 6:0 to 0x13, interrupt cause 0x10, sequence step 0 and flags 0, and raises the interrupt. With no active device it has no effect.
- R13: `intr_rd` lowers the interrupt. Opcodes 0x00, 0x1A, 0x44 and all unlisted opcodes change nothing except the command register.
- R14: While waiting for `dev_ack`, every command except chip reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_data | input | 8 | Command byte: DMA flag and opcode |
| bus_id | input | 8 | Bus-ID register; low bits select the target |
| cfg1 | input | 8 | Configuration register; bit 6 disables bus-reset reporting |
| dma_cmd_byte | input | 8 | First command byte fetched by DMA; low 3 bits are the LUN |
| intr_rd | input | 1 | Interrupt-cause register read strobe |
| dev_present | input | NTGT | One bit per attached target |
| dev_issue | output | 1 | Command issue strobe to the device |
| dev_target | output | TGTW | Target number of the issued command |
| dev_lun | output | 3 | LUN of the issued command |
| dev_ack | input | 1 | Device accepted the command |
| dev_len | input | LENW | Signed expected data length, valid with `dev_ack` |
| dev_done | input | 1 | Device completion strobe |
| dev_status | input | 8 | Completion status byte, valid with `dev_done` |
| fifo_clear | output | 1 | FIFO clear pulse |
| fifo_push | output | 1 | FIFO push strobe |
| fifo_push_data | output | 8 | Byte to push |
| xfer_start | output | 1 | Transfer counter reload pulse |
| cmd_reg | output | 8 | Last accepted command byte |
| status_reg | output | 8 | Status; bit 7 mirrors the interrupt line |
| intr_reg | output | 8 | Interrupt cause |
| seq_reg | output | 3 | Sequence step |
| flags_reg | output | FLAGW | FIFO flags field |
| irq | output | 1 | Interrupt request |

## Verification
Register outcomes land on the edge that samples the write or the device strobe, so a misdecoded opcode shows at the ports one cycle after the write. A held command that is lost or kept wrongly surfaces only at the next transfer-information command, as a missing or surplus `dev_issue` pulse, or as a wrong target or LUN. A stuck wait state shows when the next flush leaves the interrupt cause untouched. A stale last-status byte appears in the first pushed response byte. The bench compares every register after each command against a reference model, in random and directed orders.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

  typedef enum logic [3:0] {
    K_IGNORE,
    K_FLUSH,
    K_CHIPRST,
    K_BUSRST,
    K_XFER,
    K_CCS,
    K_MSGOK,
    K_SEL,
    K_SELSTOP
  } kind_e;

  typedef struct packed {
    logic  dma;
    kind_e kind;
  } dec_t;

  typedef enum logic {S_IDLE, S_WAIT} fsm_e;

  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_CHIPRST = 7'h02;
  localparam logic [6:0] OP_BUSRST  = 7'h03;
  localparam logic [6:0] OP_XFER    = 7'h10;
  localparam logic [6:0] OP_CCS     = 7'h11;
  localparam logic [6:0] OP_MSGOK   = 7'h12;
  localparam logic [6:0] OP_SEL     = 7'h42;
  localparam logic [6:0] OP_SELSTOP = 7'h43;

  localparam logic [7:0] IC_FUNC_DONE = 8'h08;
  localparam logic [7:0] IC_SERVICE   = 8'h10;
  localparam logic [7:0] IC_DISCON    = 8'h20;
  localparam logic [7:0] IC_BUSRST    = 8'h80;

  localparam logic [6:0] ST_TC        = 7'h10;
  localparam logic [6:0] PH_DATA_OUT  = 7'h00;
  localparam logic [6:0] PH_DATA_IN   = 7'h01;
  localparam logic [6:0] PH_COMMAND   = 7'h02;
  localparam logic [6:0] PH_STATUS    = 7'h03;

  localparam logic [2:0] STEP_CMD_DONE = 3'd4;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_seq_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output dec_t       dec
);

  always_comb begin
    dec.dma = cmd_byte[7];
    unique case (cmd_byte[6:0])
      OP_FLUSH:   dec.kind = K_FLUSH;
      OP_CHIPRST: dec.kind = K_CHIPRST;
      OP_BUSRST:  dec.kind = K_BUSRST;
      OP_XFER:    dec.kind = K_XFER;
      OP_CCS:     dec.kind = K_CCS;
      OP_MSGOK:   dec.kind = K_MSGOK;
      OP_SEL:     dec.kind = K_SEL;
      OP_SELSTOP: dec.kind = K_SELSTOP;
      default:    dec.kind = K_IGNORE;
    endcase
  end

endmodule

// File: rtl/scsi_resp_push.sv
module scsi_resp_push (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic [7:0] status_byte,
  output logic       push,
  output logic [7:0] push_data
);

  logic [1:0] left_q, left_d;
  logic [7:0] byte_q, byte_d;
  logic       upd;

  always_comb begin
    left_d = left_q;
    byte_d = byte_q;
    if (abort) begin
      left_d = 2'd0;
    end else if (start) begin
      left_d = 2'd2;
      byte_d = status_byte;
    end else if (left_q != 2'd0) begin
      left_d = left_q - 2'd1;
    end
  end

  assign upd = abort | start | (left_q != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= 2'd0;
      byte_q <= 8'h00;
    end else if (upd) begin
      left_q <= left_d;
      byte_q <= byte_d;
    end
  end

  assign push      = (left_q != 2'd0);
  assign push_data = (left_q == 2'd2) ? byte_q : 8'h00;

endmodule

// File: rtl/scsi_cmd_seq.sv
module scsi_cmd_seq
  import scsi_seq_pkg::*;
#(
  parameter int NTGT  = 8,
  parameter int LENW  = 17,
  parameter int FLAGW = 5,
  localparam int TGTW = (NTGT > 1) ? $clog2(NTGT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_wr,
  input  logic [7:0]             cmd_data,
  input  logic [7:0]             bus_id,
  input  logic [7:0]             cfg1,
  input  logic [7:0]             dma_cmd_byte,
  input  logic                   intr_rd,
  input  logic [NTGT-1:0]        dev_present,
  output logic                   dev_issue,
  output logic [TGTW-1:0]        dev_target,
  output logic [2:0]             dev_lun,
  input  logic                   dev_ack,
  input  logic signed [LENW-1:0] dev_len,
  input  logic                   dev_done,
  input  logic [7:0]             dev_status,
  output logic                   fifo_clear,
  output logic                   fifo_push,
  output logic [7:0]             fifo_push_data,
  output logic                   xfer_start,
  output logic [7:0]             cmd_reg,
  output logic [7:0]             status_reg,
  output logic [7:0]             intr_reg,
  output logic [2:0]             seq_reg,
  output logic [FLAGW-1:0]       flags_reg,
  output logic                   irq
);

  localparam logic [FLAGW-1:0] FLAGS_RESP = FLAGW'(2);

  // reset synchronizer: assertion asynchronous, release on clock
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  dec_t dec;
  scsi_cmd_decode u_dec (.cmd_byte(cmd_data), .dec(dec));

  fsm_e             st_q, st_d;
  logic [6:0]       stat_q, stat_d;
  logic             irq_q, irq_d;
  logic [7:0]       intr_q, intr_d;
  logic [2:0]       seq_q, seq_d;
  logic [FLAGW-1:0] flags_q, flags_d;
  logic [7:0]       cmd_q, cmd_d;
  logic             pend_q, pend_d;
  logic             act_q, act_d;
  logic [7:0]       last_q, last_d;
  logic [TGTW-1:0]  htgt_q, htgt_d;
  logic [2:0]       hlun_q, hlun_d;
  logic             issue_q, issue_d;
  logic             clr_q, clr_d;
  logic             xfer_q, xfer_d;
  logic             resp_go, resp_abort;

  logic [TGTW-1:0]  sel_tgt;
  logic             sel_ok;
  logic [2:0]       sel_lun;
  logic             len_nz, len_pos;
  logic             busy;

  assign sel_tgt = bus_id[TGTW-1:0];
  assign sel_ok  = (int'(sel_tgt) < NTGT) && dev_present[sel_tgt];
  assign sel_lun = dec.dma ? dma_cmd_byte[2:0] : 3'd0;
  assign len_nz  = (dev_len != '0);
  assign len_pos = len_nz && !dev_len[LENW-1];
  assign busy    = (st_q == S_WAIT);

  always_comb begin
    st_d    = st_q;
    stat_d  = stat_q;
    irq_d   = irq_q;
    intr_d  = intr_q;
    seq_d   = seq_q;
    flags_d = flags_q;
    cmd_d   = cmd_q;
    pend_d  = pend_q;
    act_d   = act_q;
    last_d  = last_q;
    htgt_d  = htgt_q;
    hlun_d  = hlun_q;
    issue_d = 1'b0;
    clr_d   = 1'b0;
    xfer_d  = 1'b0;
    resp_go = 1'b0;
    resp_abort = 1'b0;

    if (intr_rd) irq_d = 1'b0;

    if (cmd_wr && dec.kind == K_CHIPRST) begin
      st_d    = S_IDLE;
      stat_d  = '0;
      irq_d   = 1'b0;
      intr_d  = '0;
      seq_d   = '0;
      flags_d = '0;
      cmd_d   = '0;
      pend_d  = 1'b0;
      act_d   = 1'b0;
      last_d  = '0;
      htgt_d  = '0;
      hlun_d  = '0;
      clr_d   = 1'b1;
      resp_abort = 1'b1;
    end else if (busy) begin
      if (dev_ack) begin
        if (len_nz) stat_d = ST_TC | (len_pos ? PH_DATA_IN : PH_DATA_OUT);
        intr_d = IC_SERVICE | IC_FUNC_DONE;
        seq_d  = STEP_CMD_DONE;
        irq_d  = 1'b1;
        act_d  = 1'b1;
        st_d   = S_IDLE;
      end
    end else if (cmd_wr) begin
      cmd_d  = cmd_data;
      xfer_d = dec.dma;
      unique case (dec.kind)
        K_FLUSH: begin
          intr_d  = IC_FUNC_DONE;
          seq_d   = '0;
          flags_d = '0;
          clr_d   = 1'b1;
        end
        K_BUSRST: begin
          intr_d = IC_BUSRST;
          if (!cfg1[6]) irq_d = 1'b1;
        end
        K_XFER: begin
          if (pend_q) begin
            pend_d  = 1'b0;
            issue_d = 1'b1;
            st_d    = S_WAIT;
          end else if (dec.dma) begin
            stat_d[4] = 1'b0;
          end
        end
        K_CCS, K_MSGOK: begin
          resp_go = 1'b1;
          irq_d   = 1'b1;
          if (dec.dma) begin
            stat_d = ST_TC | PH_STATUS;
            intr_d = IC_SERVICE | IC_FUNC_DONE;
            seq_d  = STEP_CMD_DONE;
          end else begin
            flags_d = FLAGS_RESP;
          end
          if (dec.kind == K_MSGOK) begin
            intr_d = IC_DISCON;
            seq_d  = '0;
          end
        end
        K_SEL, K_SELSTOP: begin
          clr_d  = 1'b1;
          act_d  = 1'b0;
          pend_d = 1'b0;
          if (!sel_ok) begin
            stat_d = '0;
            intr_d = IC_DISCON;
            seq_d  = '0;
            irq_d  = 1'b1;
          end else begin
            htgt_d = sel_tgt;
            hlun_d = sel_lun;
            if (dec.kind == K_SEL) begin
              issue_d = 1'b1;
              st_d    = S_WAIT;
            end else begin
              pend_d = 1'b1;
              stat_d = ST_TC | PH_COMMAND;
              intr_d = IC_SERVICE | IC_FUNC_DONE;
              seq_d  = STEP_CMD_DONE;
              irq_d  = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else if (dev_done && act_q) begin
      last_d  = dev_status;
      stat_d  = ST_TC | PH_STATUS;
      intr_d  = IC_SERVICE;
      seq_d   = '0;
      flags_d = '0;
      irq_d   = 1'b1;
      act_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q    <= S_IDLE;
      stat_q  <= '0;
      irq_q   <= 1'b0;
      intr_q  <= '0;
      seq_q   <= '0;
      flags_q <= '0;
      cmd_q   <= '0;
      pend_q  <= 1'b0;
      act_q   <= 1'b0;
      last_q  <= '0;
      htgt_q  <= '0;
      hlun_q  <= '0;
      issue_q <= 1'b0;
      clr_q   <= 1'b0;
      xfer_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      stat_q  <= stat_d;
      irq_q   <= irq_d;
      intr_q  <= intr_d;
      seq_q   <= seq_d;
      flags_q <= flags_d;
      cmd_q   <= cmd_d;
      pend_q  <= pend_d;
      act_q   <= act_d;
      last_q  <= last_d;
      htgt_q  <= htgt_d;
      hlun_q  <= hlun_d;
      issue_q <= issue_d;
      clr_q   <= clr_d;
      xfer_q  <= xfer_d;
    end
  end

  scsi_resp_push u_resp (
    .clk(clk), .rst_n(srst_n), .start(resp_go), .abort(resp_abort),
    .status_byte(last_q), .push(fifo_push), .push_data(fifo_push_data)
  );

  assign dev_issue  = issue_q;
  assign dev_target = htgt_q;
  assign dev_lun    = hlun_q;
  assign fifo_clear = clr_q;
  assign xfer_start = xfer_q;
  assign cmd_reg    = cmd_q;
  assign status_reg = {irq_q, stat_q};
  assign intr_reg   = intr_q;
  assign seq_reg    = seq_q;
  assign flags_reg  = flags_q;
  assign irq        = irq_q;

endmodule

// File: rtl/scsi_cmd_seq_chk.sv
module scsi_cmd_seq_chk #(
  parameter int NTGT = 8,
  parameter int LENW = 17,
  parameter int TGTW = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   cmd_wr,
  input logic [7:0]             cmd_data,
  input logic [7:0]             bus_id,
  input logic [7:0]             cfg1,
  input logic                   intr_rd,
  input logic [NTGT-1:0]        dev_present,
  input logic                   dev_issue,
  input logic                   dev_ack,
  input logic signed [LENW-1:0] dev_len,
  input logic                   fifo_clear,
  input logic [7:0]             status_reg,
  input logic [7:0]             intr_reg,
  input logic [2:0]             seq_reg,
  input logic                   irq
);

  logic is_rst, idle_wr;
  assign is_rst  = cmd_wr && (cmd_data[6:0] == 7'h02);
  assign idle_wr = cmd_wr && !busy;

  assert_chip_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_rst |=> (status_reg == 8'h00 && intr_reg == 8'h00 && !irq));

  assert_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle_wr && cmd_data[6:0] == 7'h01 |=>
      (intr_reg == 8'h08 && seq_reg == 3'd0 && fifo_clear));

  assert_busrst_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_wr && cmd_data[6:0] == 7'h03 && cfg1[6] && !irq |=>
      (!irq && intr_reg == 8'h80));

  assert_absent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_wr && (cmd_data[6:0] == 7'h42 || cmd_data[6:0] == 7'h43) &&
    !dev_present[bus_id[TGTW-1:0]] |=>
      (status_reg == 8'h80 && intr_reg == 8'h20 && seq_reg == 3'd0));

  assert_issue_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_issue |=> !dev_issue);

  assert_ack_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dev_ack && dev_len > 0 && !is_rst |=>
      (status_reg == 8'h91 && intr_reg == 8'h18 && seq_reg == 3'd4));

  assert_wait_ignores_R14: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr && !is_rst && !dev_ack |=> ($stable(intr_reg) && !fifo_clear));

endmodule

bind scsi_cmd_seq scsi_cmd_seq_chk #(.NTGT(NTGT), .LENW(LENW), .TGTW(TGTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
  .bus_id(bus_id), .cfg1(cfg1), .intr_rd(intr_rd), .dev_present(dev_present),
  .dev_issue(dev_issue), .dev_ack(dev_ack), .dev_len(dev_len),
  .fifo_clear(fifo_clear), .status_reg(status_reg), .intr_reg(intr_reg),
  .seq_reg(seq_reg), .irq(irq)
);

// File: tb/test_scsi_cmd_seq.sv
`timescale 1ns/1ps
module test_scsi_cmd_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_data = '0, bus_id = '0, cfg1 = '0, dma_cmd_byte = '0;
  logic intr_rd = 1'b0;
  logic [7:0] dev_present = '0;
  logic dev_issue;
  logic [2:0] dev_target, dev_lun;
  logic dev_ack = 1'b0;
  logic signed [16:0] dev_len = '0;
  logic dev_done = 1'b0;
  logic [7:0] dev_status = '0;
  logic fifo_clear, fifo_push, xfer_start, irq;
  logic [7:0] fifo_push_data, cmd_reg, status_reg, intr_reg;
  logic [2:0] seq_reg;
  logic [4:0] flags_reg;

  always #2.5 clk = ~clk;

  scsi_cmd_seq i_scsi_cmd_seq (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model
  logic [6:0] m_stat; logic m_irq; logic [7:0] m_intr; logic [2:0] m_seq;
  logic [4:0] m_flags; logic [7:0] m_cmd, m_last; logic m_pend, m_act;
  logic [2:0] m_tgt, m_lun;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_stat = 0; m_irq = 0; m_intr = 0; m_seq = 0; m_flags = 0; m_cmd = 0;
    m_last = 0; m_pend = 0; m_act = 0; m_tgt = 0; m_lun = 0;
  endtask

  task automatic chk_regs(input string req);
    chk({req, " status"}, status_reg, {m_irq, m_stat});
    chk({req, " intr"}, intr_reg, m_intr);
    chk({req, " seq"}, seq_reg, m_seq);
    chk({req, " flags"}, flags_reg, m_flags);
    chk({req, " cmd"}, cmd_reg, m_cmd);
  endtask

  function automatic logic [6:0] ack_stat(input logic [6:0] s, input logic signed [16:0] l);
    if (l == 0) return s;
    return 7'h10 | ((l > 0) ? 7'h01 : 7'h00);
  endfunction

  task automatic run_cmd(input logic [7:0] c, input logic signed [16:0] len);
    logic [6:0] op = c[6:0];
    bit dma = c[7];
    bit e_issue = 0, e_clear = 0, e_resp = 0, e_xfer = 0;
    logic [2:0] tgt = bus_id[2:0];
    logic [7:0] rbyte = m_last;
    if (op == 7'h02) begin
      model_reset(); e_clear = 1;
    end else begin
      m_cmd = c; e_xfer = dma;
      case (op)
        7'h01: begin m_intr = 8'h08; m_seq = 0; m_flags = 0; e_clear = 1; end
        7'h03: begin m_intr = 8'h80; if (!cfg1[6]) m_irq = 1; end
        7'h10: begin
          if (m_pend) begin m_pend = 0; e_issue = 1; end
          else if (dma) m_stat[4] = 1'b0;
        end
        7'h11, 7'h12: begin
          e_resp = 1; m_irq = 1;
          if (dma) begin m_stat = 7'h13; m_intr = 8'h18; m_seq = 4; end
          else m_flags = 2;
          if (op == 7'h12) begin m_intr = 8'h20; m_seq = 0; end
        end
        7'h42, 7'h43: begin
          e_clear = 1; m_act = 0; m_pend = 0;
          if (!dev_present[tgt]) begin
            m_stat = 0; m_intr = 8'h20; m_seq = 0; m_irq = 1;
          end else begin
            m_tgt = tgt; m_lun = dma ? dma_cmd_byte[2:0] : 3'd0;
            if (op == 7'h42) e_issue = 1;
            else begin m_pend = 1; m_stat = 7'h12; m_intr = 8'h18; m_seq = 4; m_irq = 1; end
          end
        end
        default: ;
      endcase
    end
    @(negedge clk); cmd_wr = 1; cmd_data = c;
    @(negedge clk); cmd_wr = 0;
    chk("R1 xfer_start", xfer_start, e_xfer);
    chk("R3/R5 fifo_clear", fifo_clear, e_clear);
    chk("R6/R8 dev_issue", dev_issue, e_issue);
    chk("R10 push first", {fifo_push, (e_resp ? fifo_push_data : 8'h00)}, {e_resp, (e_resp ? rbyte : 8'h00)});
    chk_regs("R13 after command");
    if (e_resp) begin
      @(negedge clk);
      chk("R10 push second", {fifo_push, fifo_push_data}, {1'b1, 8'h00});
    end
    if (e_issue) begin
      chk("R6 dev_target", dev_target, m_tgt);
      chk("R6 dev_lun", dev_lun, m_lun);
      dev_ack = 1; dev_len = len;
      @(negedge clk); dev_ack = 0;
      m_stat = ack_stat(m_stat, len); m_intr = 8'h18; m_seq = 4; m_irq = 1; m_act = 1;
      chk_regs("R7 after ack");
    end
  endtask

  task automatic run_done(input logic [7:0] s);
    @(negedge clk); dev_done = 1; dev_status = s;
    @(negedge clk); dev_done = 0;
    if (m_act) begin
      m_last = s; m_stat = 7'h13; m_intr = 8'h10; m_seq = 0; m_flags = 0; m_irq = 1; m_act = 0;
    end
    chk_regs("R12 done");
  endtask

  task automatic run_rd();
    @(negedge clk); intr_rd = 1;
    @(negedge clk); intr_rd = 0;
    m_irq = 0;
    chk_regs("R13 intr read");
  endtask

  function automatic logic signed [16:0] rnd_len();
    int k = $urandom_range(0, 2);
    if (k == 0) return 17'sd0;
    if (k == 1) return 17'($urandom_range(1, 65535));
    return -17'($urandom_range(1, 65536));
  endfunction

  initial begin
    logic [7:0] ops [11] = '{8'h00, 8'h01, 8'h03, 8'h10, 8'h11, 8'h12, 8'h1A, 8'h42, 8'h43, 8'h44, 8'h55};
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_regs("R2 reset state");
    chk("R2 irq at reset", irq, 1'b0);

    // directed corners
    dev_present = 8'b0010_0100; bus_id = 8'hF2; dma_cmd_byte = 8'h0D;
    run_cmd(8'h42, 17'sd12);           // R6 non-DMA LUN 0, R7 data in
    run_done(8'h02);                    // R12
    run_cmd(8'h11, 0);                  // R10 non-DMA, last status 0x02
    run_cmd(8'h91, 0);                  // R10 DMA
    run_rd();                           // R13
    run_cmd(8'hC2, -17'sd5);            // R6 DMA LUN 5, R7 data out
    run_cmd(8'h42, 17'sd0);             // R7 zero length keeps status
    bus_id = 8'h03;
    run_cmd(8'h43, 0);                  // R5 absent target
    bus_id = 8'h05;
    run_cmd(8'hC3, 0);                  // R8 held command, LUN 5
    run_cmd(8'h10, 17'sd7);             // R8 issue held
    run_cmd(8'h90, 0);                  // R9 clears terminal count
    cfg1 = 8'h40; run_rd();
    run_cmd(8'h03, 0);                  // R4 suppressed
    chk("R4 irq suppressed", irq, 1'b0);
    cfg1 = 8'h00;
    run_cmd(8'h03, 0);                  // R4 reported
    run_cmd(8'h12, 0);                  // R11
    run_cmd(8'h1A, 0);                  // R13 no effect
    run_cmd(8'h01, 0);                  // R3
    // R14: command during wait is ignored
    bus_id = 8'h02;
    @(negedge clk); cmd_wr = 1; cmd_data = 8'h42;
    @(negedge clk); cmd_wr = 0; m_cmd = 8'h42; m_act = 0; m_tgt = 2; m_lun = 0;
    cmd_wr = 1; cmd_data = 8'h01;
    @(negedge clk); cmd_wr = 0;
    chk("R14 no clear while waiting", fifo_clear, 1'b0);
    chk_regs("R14 ignored in wait");
    dev_ack = 1; dev_len = -17'sd3;
    @(negedge clk); dev_ack = 0;
    m_stat = 7'h10; m_intr = 8'h18; m_seq = 4; m_irq = 1; m_act = 1;
    chk_regs("R14 ack after ignored command");
    run_cmd(8'h82, 0);                  // R2 chip reset, with DMA flag
    chk("R2 irq low", irq, 1'b0);
    run_done(8'h77);                    // R12 ignored with no active device

    // random phase
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 19);
      dev_present = 8'($urandom); bus_id = 8'($urandom);
      cfg1 = ($urandom_range(0, 1) != 0) ? 8'h40 : 8'h00;
      dma_cmd_byte = 8'($urandom);
      if (r < 14) run_cmd({1'($urandom), ops[$urandom_range(0, 10)][6:0]}, rnd_len());
      else if (r < 17) run_done(8'($urandom));
      else if (r < 19) run_rd();
      else run_cmd(8'h02, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule